// File: doc/BRIEF.md
# Periodic Wake-Up Interrupt Timer

The block is a periodic timer that sets a flag once per programmed period and raises an interrupt while that flag is set and interrupts are enabled. Each period is measured in ticks of a selected time base. One choice is an always-on oscillator, presented to the block as a one-cycle tick strobe synchronous to `clk_i`. The other is the bus clock, presented as a "bus clock running" qualifier. When the bus clock is selected and stopped, the timer holds its count.

Software drives a small register interface. A control word holds the run enable, the time-base select, the interrupt enable, the pin output enable and the write-one-to-clear flag. A second word holds the 16-bit period value. The time-base select and the period value are frozen while the timer runs, so a change follows a fixed order: stop the timer, write the new settings, start it again. After each expiry the counter restarts by itself. An optional external pin toggles at every expiry, which gives a square wave.

Top module: `periodic_irq_timer`

## Requirements
- R1: After reset, the control word and the period word read 0, and `irq_o` and `ext_pin_o` are 0.
- R2: The time-base select (control bit 1) ignores writes while the run enable (control bit 0) is 1, and accepts them while the run enable is 0.
- R3: The period word (address 1) ignores writes while the run enable is 1, and accepts them while the run enable is 0.
- R4: The write that sets the run enable lands on some edge E. With period value P, the flag (control bit 4) becomes 1 on edge E+2(P+1) when the selected time base ticks every cycle, and the counter then restarts at once for the next period.
- R5: With select 0 the counter advances only in cycles with `osc_tick_i`=1. With select 1 it advances only in cycles with `bus_active_i`=1.
- R6: `irq_o` is 1 exactly when the flag and the interrupt enable (control bit 2) are both 1.
- R7: Writing control data with bit 4 set clears the flag. An expiry in the same cycle takes priority, so the flag stays 1.
- R8: With the pin enable (control bit 3) set, `ext_pin_o` toggles on every expiry. With the pin enable clear, `ext_pin_o` is 0.
- R9: Clearing the run enable drives the internal pin state low and resets the counter, so a later enable starts a full period.
- R10: With select 1 and `bus_active_i`=0, the count holds and no expiry occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| osc_tick_i | input | 1 | One-cycle strobe per always-on oscillator period |
| bus_active_i | input | 1 | High while the bus clock is running |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | Write address: 0 control, 1 period |
| wr_data_i | input | 16 | Write data |
| rd_addr_i | input | 1 | Read address: 0 control, 1 period |
| rd_data_o | output | 16 | Read data, combinational |
| irq_o | output | 1 | Interrupt request |
| ext_pin_o | output | 1 | External square-wave output |

## Verification
The bench builds the block with its default 16-bit period width. It programs period values 0, 1 and 2, which keep each expiry within a handful of cycles. Expiry edges can therefore be predicted exactly and queued for the scoreboard, and several restarts fit in a short run. The small periods also bring within reach the tick-by-tick checks: oscillator selection, bus-clock freezing and the cycle in which an expiry coincides with a flag clear.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int unsigned PER_W = 16;

  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_PER  = 1'b1;

  localparam int unsigned B_RUN  = 0;
  localparam int unsigned B_SEL  = 1;
  localparam int unsigned B_IEN  = 2;
  localparam int unsigned B_PEN  = 3;
  localparam int unsigned B_FLAG = 4;

  typedef struct packed {
    logic run;
    logic sel_bus;
    logic irq_en;
    logic pin_en;
  } pit_ctrl_t;
endpackage

// File: rtl/pit_regs.sv
module pit_regs
  import pit_pkg::*;
#(
  parameter int unsigned DW = PER_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_addr_i,
  input  logic          expire_i,
  output logic [DW-1:0] rd_data_o,
  output pit_ctrl_t     ctrl_o,
  output logic [DW-1:0] period_o,
  output logic          flag_o
);
  pit_ctrl_t     ctrl_q;
  logic [DW-1:0] per_q;
  logic          flag_q;
  logic          wr_ctrl, wr_per;

  assign wr_ctrl = wr_en_i && (wr_addr_i == ADDR_CTRL);
  assign wr_per  = wr_en_i && (wr_addr_i == ADDR_PER);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      per_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.run    <= wr_data_i[B_RUN];
        ctrl_q.irq_en <= wr_data_i[B_IEN];
        ctrl_q.pin_en <= wr_data_i[B_PEN];
        if (!ctrl_q.run) ctrl_q.sel_bus <= wr_data_i[B_SEL];
      end
      if (wr_per && !ctrl_q.run) per_q <= wr_data_i;
      // expiry wins over a same-cycle clear
      if (expire_i)                           flag_q <= 1'b1;
      else if (wr_ctrl && wr_data_i[B_FLAG])  flag_q <= 1'b0;
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == ADDR_PER) begin
      rd_data_o = per_q;
    end else begin
      rd_data_o[B_RUN]  = ctrl_q.run;
      rd_data_o[B_SEL]  = ctrl_q.sel_bus;
      rd_data_o[B_IEN]  = ctrl_q.irq_en;
      rd_data_o[B_PEN]  = ctrl_q.pin_en;
      rd_data_o[B_FLAG] = flag_q;
    end
  end

  assign ctrl_o   = ctrl_q;
  assign period_o = per_q;
  assign flag_o   = flag_q;

  AST_SEL_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q.run |=> $stable(ctrl_q.sel_bus)); // R2
  AST_PER_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q.run |=> $stable(per_q)); // R3
  AST_EXPIRE_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i |=> flag_q); // R7
endmodule

// File: rtl/pit_tick_sel.sv
module pit_tick_sel (
  input  logic sel_bus_i,
  input  logic osc_tick_i,
  input  logic bus_active_i,
  output logic tick_o
);
  // gated selection; a stopped bus clock yields no ticks
  assign tick_o = sel_bus_i ? bus_active_i : osc_tick_i;
endmodule

// File: rtl/pit_counter.sv
module pit_counter #(
  parameter int unsigned PW = 16,
  localparam int unsigned CW = PW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          tick_i,
  input  logic [PW-1:0] period_i,
  output logic          expire_o,
  output logic          pin_o
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;
  logic          pin_q;

  // 2*(P+1) ticks per period -> terminal count 2P+1
  assign last     = {period_i, 1'b1};
  assign expire_o = run_i && tick_i && (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      pin_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      pin_q <= 1'b0;
    end else if (tick_i) begin
      if (cnt_q == last) begin
        cnt_q <= '0;
        pin_q <= ~pin_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign pin_o = pin_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && $stable(period_i) |-> cnt_q <= last); // R4
  AST_IDLE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0) && !pin_q); // R9
  AST_PIN_ON_EXPIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> pin_q != $past(pin_q)); // R8
endmodule

// File: rtl/periodic_irq_timer.sv
module periodic_irq_timer
  import pit_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             osc_tick_i,
  input  logic             bus_active_i,
  input  logic             wr_en_i,
  input  logic             wr_addr_i,
  input  logic [PER_W-1:0] wr_data_i,
  input  logic             rd_addr_i,
  output logic [PER_W-1:0] rd_data_o,
  output logic             irq_o,
  output logic             ext_pin_o
);
  pit_ctrl_t        ctrl;
  logic [PER_W-1:0] period;
  logic             flag, tick, expire, pin;

  pit_regs #(.DW(PER_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .rd_addr_i,
    .expire_i (expire),
    .rd_data_o,
    .ctrl_o   (ctrl),
    .period_o (period),
    .flag_o   (flag)
  );

  pit_tick_sel u_tick (
    .sel_bus_i    (ctrl.sel_bus),
    .osc_tick_i,
    .bus_active_i,
    .tick_o       (tick)
  );

  pit_counter #(.PW(PER_W)) u_cnt (
    .clk_i, .rst_ni,
    .run_i    (ctrl.run),
    .tick_i   (tick),
    .period_i (period),
    .expire_o (expire),
    .pin_o    (pin)
  );

  assign irq_o     = flag && ctrl.irq_en;
  assign ext_pin_o = pin && ctrl.pin_en;

  AST_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl.run && ctrl.sel_bus && !bus_active_i |-> !expire); // R10
  AST_OSC_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl.sel_bus && !osc_tick_i |-> !expire); // R5
  AST_PIN_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl.pin_en |-> !ext_pin_o); // R8
endmodule

// File: tb/periodic_irq_timer_test.sv
module periodic_irq_timer_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        osc_tick = 1'b0, bus_active = 1'b1;
  logic        wr_en = 1'b0, wr_addr = 1'b0, rd_addr = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        irq, pin;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int exp_q[$];
  bit mon_en = 0, done = 0;
  logic pin_prev = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  periodic_irq_timer uut (
    .clk_i(clk), .rst_ni(rst_n), .osc_tick_i(osc_tick), .bus_active_i(bus_active),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .irq_o(irq), .ext_pin_o(pin)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // control bits: 0 run, 1 sel_bus, 2 irq_en, 3 pin_en, 4 flag (w1c)
  task automatic wr(input logic a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic a, output logic [15:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  // scoreboard monitor: each pin edge pops the expected edge number
  always @(negedge clk) begin
    if (mon_en && pin !== pin_prev) begin
      if (exp_q.size() == 0) chk(1'b0, "R8 unexpected pin edge", cyc, -1);
      else begin
        int e;
        e = exp_q.pop_front();
        chk(cyc == e, "R4/R8 expiry edge", cyc, e);
      end
    end
    pin_prev <= pin;
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    logic [15:0] d;
    int e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(0, d); chk(d == 0, "R1 ctrl", d, 0);
    rd(1, d); chk(d == 0, "R1 period", d, 0);
    chk(irq == 0, "R1 irq", irq, 0);
    chk(pin == 0, "R1 pin", pin, 0);

    // R4/R8 bus time base, P=2 -> 6 cycles per expiry
    wr(1, 16'd2);
    wr(0, 16'h000E);
    wr(0, 16'h000F);
    e = cyc;
    exp_q.push_back(e + 6); exp_q.push_back(e + 12); exp_q.push_back(e + 18);
    mon_en = 1;
    wait_until(e + 5);
    rd(0, d); chk(d[4] == 0, "R4 flag before expiry", d[4], 0);
    wait_until(e + 6);
    rd(0, d); chk(d[4] == 1, "R4 flag at expiry", d[4], 1);
    chk(irq == 1, "R6 irq with flag and enable", irq, 1);
    wr(0, 16'h001F);                       // R7 clear, lands at e+7
    rd(0, d); chk(d[4] == 0, "R7 flag cleared", d[4], 0);
    chk(irq == 0, "R6 irq follows flag", irq, 0);
    wr(1, 16'd9);                          // R3 locked
    rd(1, d); chk(d == 16'd2, "R3 period locked", d, 2);
    wr(0, 16'h000D);                       // R2 try sel=0 while running
    rd(0, d); chk(d[1] == 1, "R2 sel locked", d[1], 1);
    wait_until(e + 19);
    mon_en = 0;
    chk(exp_q.size() == 0, "R4 restarts", exp_q.size(), 0);
    chk(pin == 1, "R8 pin high after 3 toggles", pin, 1);

    // R9 disable drives pin low
    wr(0, 16'h000E);
    @(negedge clk);
    chk(pin == 0, "R9 pin low after disable", pin, 0);
    wr(1, 16'd1);
    rd(1, d); chk(d == 16'd1, "R3 period writable when idle", d, 1);

    // R6 mask
    wr(0, 16'h0002);
    rd(0, d); chk(d[4] == 1, "R6 flag kept", d[4], 1);
    chk(irq == 0, "R6 irq masked", irq, 0);
    wr(0, 16'h0012);
    rd(0, d); chk(d[4] == 0, "R7 flag cleared idle", d[4], 0);

    // R5 oscillator time base, P=1 -> 4 ticks
    wr(0, 16'h0000);
    rd(0, d); chk(d[1] == 0, "R2 sel writable when idle", d[1], 0);
    wr(0, 16'h0005);
    repeat (10) @(negedge clk);
    rd(0, d); chk(d[4] == 0, "R5 bus cycles ignored on osc", d[4], 0);
    for (int i = 0; i < 3; i++) begin
      osc_tick = 1'b1; @(negedge clk); osc_tick = 1'b0; @(negedge clk);
    end
    rd(0, d); chk(d[4] == 0, "R5 three osc ticks", d[4], 0);
    osc_tick = 1'b1; @(negedge clk); osc_tick = 1'b0;
    rd(0, d); chk(d[4] == 1, "R5 fourth osc tick expires", d[4], 1);
    chk(irq == 1, "R6 irq on osc expiry", irq, 1);

    // R10 freeze on stopped bus clock
    wr(0, 16'h0000);
    wr(0, 16'h0012);
    rd(0, d); chk(d == 16'h0002, "R2 sel set, flag cleared", d, 2);
    bus_active = 1'b0;
    wr(0, 16'h0003);
    repeat (20) @(negedge clk);
    rd(0, d); chk(d[4] == 0, "R10 frozen", d[4], 0);
    bus_active = 1'b1;
    repeat (3) @(negedge clk);
    rd(0, d); chk(d[4] == 0, "R10 count held, R9 full period", d[4], 0);
    @(negedge clk);
    rd(0, d); chk(d[4] == 1, "R10 resumes and expires", d[4], 1);

    // P=0, expiry coinciding with clear
    wr(0, 16'h0012);
    wr(1, 16'd0);
    wr(0, 16'h000B);
    e = cyc;
    exp_q.push_back(e + 2); exp_q.push_back(e + 4); exp_q.push_back(e + 6);
    mon_en = 1;
    wait_until(e + 5);
    wr(0, 16'h001B);                       // lands on e+6, an expiry edge
    rd(0, d); chk(d[4] == 1, "R7 expiry beats clear", d[4], 1);
    wait_until(e + 7);
    mon_en = 0;
    chk(exp_q.size() == 0, "R4 P=0 expiries", exp_q.size(), 0);

    // R8 pin masked when pin enable clear
    wr(0, 16'h0003);
    for (int i = 0; i < 4; i++) begin
      chk(pin == 0, "R8 pin gated", pin, 0);
      @(negedge clk);
    end

    finish_run();
  end
endmodule